// File: doc/BRIEF.md
# Bidirectional GPIO Port with Bitwise Read-Modify-Write

This block is an 8-bit general-purpose I/O port that sits on a simple microcontroller register bus. Each pin has a direction bit in a mode register, a bit in a shared output latch, a tri-state output enable and an input path through a two-flop synchronizer. The bus can write a whole byte, read a whole byte, or set, clear or toggle a single bit. A single-bit operation is always done as a full-width read-modify-write that finishes in one clock cycle.

The value read from the port is mixed per bit. Output-mode bits return the latch and input-mode bits return the synchronized pin level. A single-bit operation starts from that same mixed value and writes all eight bits back to the latch. In a port with mixed directions, the latch bits of input pins therefore take on the sampled pin levels, even when they are not the target bit. Software that later turns such a pin into an output must rewrite its latch bit first.

Top module: `gpio_rmw_port`

## Requirements
- R1: A bus write with op 00 to address 0 (`sel_i`=1, `we_i`=1, `addr_i`=0) stores `wdata_i` into the output latch whatever the mode bits are. The stored value is on `pin_o` after the next rising clock edge.
- R2: `pin_oe_o[i]` is 1 exactly when mode bit i is 0 (output mode), and `pin_o` always carries the output latch.
- R3: Writing the latch while a bit is in input mode leaves that bit's output enable low. The stored value becomes the driven and read-back value as soon as the bit is switched to output mode.
- R4: The output latch changes only on a port write or bit operation (`sel_i`=1, `we_i`=1, `addr_i`=0). Reads, writes to the mode register and strobes without `sel_i` leave it unchanged.
- R5: While `rst_ni` is low, the latch is cleared to 0x00 and the mode register is set to 0xFF (all inputs), so no pin is driven.
- R6: A read at address 0 returns the latch value for output-mode bits and the synchronized pin level for input-mode bits. A change on `pin_i` shows up in `rdata_o` two rising edges after it is applied.
- R7: Op 01 sets, op 10 clears and op 11 toggles bit `bit_i` of the addressed register. The result is in place after one rising edge.
- R8: In a bit operation on address 0, every other latch bit is rewritten from the mixed read value. Output-mode bits keep their latch value, and input-mode bits take the synchronized pin level.
- R9: Address 1 selects the mode register (1 = input, 0 = output). It accepts the same four ops on its own contents, and `rdata_o` returns it when `addr_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Decoded select for this port |
| we_i | input | 1 | Write strobe |
| addr_i | input | 1 | 0 = port data, 1 = mode register |
| op_i | input | 2 | 00 write, 01 set, 10 clear, 11 toggle |
| bit_i | input | 3 | Target bit of a single-bit op |
| wdata_i | input | 8 | Write data for op 00 |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| pin_i | input | 8 | Pin levels |
| pin_o | output | 8 | Output latch, driven to the pins |
| pin_oe_o | output | 8 | Per-pin output enable |

## Verification
A write or a bit operation lands on the rising edge where it is presented, so the latch, `pin_o`, `pin_oe_o` and the mode read-back are compared at the falling edge that follows. Pin stimulus needs two rising edges before it can be read or used in a read-modify-write. The vector loop therefore holds each pin pattern for three edges before it issues the bus operation. A directed test steps a pin change one edge at a time and checks that `rdata_o` keeps the old level after one edge and shows the new level after two. Because `rdata_o` is combinational, every read is sampled at a falling edge with the bus idle.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;
  typedef enum logic [1:0] {
    OP_WRITE  = 2'b00,
    OP_SET    = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_TOGGLE = 2'b11
  } port_op_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] mode_i,   // 1 = input
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] merged_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign merged_o[b] = mode_i[b] ? pin_i[b] : latch_i[b];
  end
endmodule

// File: rtl/gpio_bit_alu.sv
module gpio_bit_alu
  import gpio_rmw_pkg::*;
#(
  parameter  int WIDTH = 8,
  localparam int IdxW  = $clog2(WIDTH)
) (
  input  port_op_e         op_i,
  input  logic [IdxW-1:0]  idx_i,
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] result_o
);
  logic [WIDTH-1:0] mask;

  always_comb begin
    mask = '0;
    mask[idx_i] = 1'b1;
    unique case (op_i)
      OP_WRITE:  result_o = wdata_i;
      OP_SET:    result_o = src_i | mask;
      OP_CLEAR:  result_o = src_i & ~mask;
      OP_TOGGLE: result_o = src_i ^ mask;
      default:   result_o = src_i;
    endcase
  end
endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
  import gpio_rmw_pkg::*;
#(
  parameter  int WIDTH       = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int IdxW        = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [1:0]       op_i,
  input  logic [IdxW-1:0]  bit_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o
);
  localparam logic ADDR_PORT = 1'b0;
  localparam logic ADDR_MODE = 1'b1;

  logic [WIDTH-1:0] mode_q, latch_q, pin_sync, port_rd, latch_nxt, mode_nxt;
  logic             port_wr, mode_wr;
  port_op_e         op;

  assign op      = port_op_e'(op_i);
  assign port_wr = sel_i && we_i && (addr_i == ADDR_PORT);
  assign mode_wr = sel_i && we_i && (addr_i == ADDR_MODE);

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  // Per-bit source: shared by bus reads and the RMW path
  gpio_read_mux #(.WIDTH(WIDTH)) i_rd_mux (
    .mode_i  (mode_q),
    .latch_i (latch_q),
    .pin_i   (pin_sync),
    .merged_o(port_rd)
  );

  gpio_bit_alu #(.WIDTH(WIDTH)) i_port_alu (
    .op_i    (op),
    .idx_i   (bit_i),
    .src_i   (port_rd),
    .wdata_i (wdata_i),
    .result_o(latch_nxt)
  );

  gpio_bit_alu #(.WIDTH(WIDTH)) i_mode_alu (
    .op_i    (op),
    .idx_i   (bit_i),
    .src_i   (mode_q),
    .wdata_i (wdata_i),
    .result_o(mode_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      mode_q  <= '1;
    end else begin
      if (port_wr) latch_q <= latch_nxt;
      if (mode_wr) mode_q  <= mode_nxt;
    end
  end

  assign rdata_o  = (addr_i == ADDR_MODE) ? mode_q : port_rd;
  assign pin_o    = latch_q;
  assign pin_oe_o = ~mode_q;

  // ---------------- assertions ----------------
  a_r1_byte_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && !addr_i && op_i == 2'b00) |=> pin_o == $past(wdata_i));

  a_r4_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && we_i && !addr_i) |=> $stable(pin_o));

  a_r7_set_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && !addr_i && op_i == 2'b01) |=> pin_o[$past(bit_i)]);

  a_r7_clear_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && !addr_i && op_i == 2'b10) |=> !pin_o[$past(bit_i)]);

  // R8: untargeted bits come from latch (outputs) or synced pin (inputs)
  a_r8_rmw_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && !addr_i && op_i != 2'b00) |=>
      (((pin_o ^ (($past(pin_o) & $past(pin_oe_o)) | ($past(pin_sync) & ~$past(pin_oe_o))))
        & ~(WIDTH'(1) << $past(bit_i))) == '0));

  a_r6_read_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i |-> ((rdata_o ^ pin_o) & pin_oe_o) == '0);

  a_r9_mode_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && we_i && addr_i) |=> $stable(pin_oe_o));
endmodule

// File: tb/test_gpio_rmw_port.sv
`timescale 1ns/1ps
module test_gpio_rmw_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0, addr = 1'b0;
  logic [1:0] op = 2'b00;
  logic [2:0] idx = 3'd0;
  logic [7:0] wdata = 8'h00, pin = 8'h00;
  logic [7:0] rdata, pout, poe;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_rmw_port i_gpio_rmw_port (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .op_i(op), .bit_i(idx), .wdata_i(wdata), .rdata_o(rdata),
    .pin_i(pin), .pin_o(pout), .pin_oe_o(poe)
  );

  typedef struct packed {
    logic       sel;
    logic       addr;
    logic [1:0] op;
    logic [2:0] idx;
    logic [7:0] wdata;
    logic [7:0] pin;
    logic [7:0] exp_rd;   // port read after the op
    logic [7:0] exp_out;  // latch on pin_o after the op
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 2'b00, 3'd0, 8'h0F, 8'hA5, 8'h05, 8'h00}, // R9 mode=0F, R3
    '{1'b1, 1'b0, 2'b00, 3'd0, 8'h3C, 8'hA5, 8'h35, 8'h3C}, // R1 R6
    '{1'b1, 1'b0, 2'b01, 3'd7, 8'h00, 8'h5A, 8'hBA, 8'hBA}, // R7 set, R8
    '{1'b1, 1'b0, 2'b10, 3'd1, 8'h00, 8'h0F, 8'hBF, 8'hBD}, // R7 clear, R8
    '{1'b1, 1'b0, 2'b11, 3'd4, 8'h00, 8'h00, 8'hA0, 8'hA0}, // R7 toggle, R8
    '{1'b1, 1'b1, 2'b11, 3'd7, 8'h00, 8'hFF, 8'hAF, 8'hA0}, // R9 toggle mode, R4
    '{1'b1, 1'b1, 2'b00, 3'd0, 8'h00, 8'h00, 8'hA0, 8'hA0}, // R9 all outputs
    '{1'b1, 1'b0, 2'b00, 3'd0, 8'h5A, 8'hFF, 8'h5A, 8'h5A}, // R1 R6
    '{1'b1, 1'b0, 2'b01, 3'd0, 8'h00, 8'h00, 8'h5B, 8'h5B}, // R7 R8
    '{1'b1, 1'b1, 2'b00, 3'd0, 8'hFF, 8'h12, 8'h12, 8'h5B}, // R9 all inputs, R6
    '{1'b1, 1'b0, 2'b10, 3'd4, 8'h00, 8'h12, 8'h12, 8'h02}, // R8 inputs overwrite latch
    '{1'b1, 1'b1, 2'b00, 3'd0, 8'h00, 8'h12, 8'h02, 8'h02}, // R3 latch now read back
    '{1'b0, 1'b0, 2'b00, 3'd0, 8'hFF, 8'h00, 8'h02, 8'h02}  // R4 no select
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_op(logic s, logic a, logic [1:0] o, logic [2:0] b, logic [7:0] d);
    sel = s; we = 1'b1; addr = a; op = o; idx = b; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; we = 1'b0; addr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5 reset state
    check("R5 latch", pout, 8'h00);
    check("R5 oe", poe, 8'h00);
    addr = 1'b1; #0.1;
    check("R5 mode", rdata, 8'hFF);
    addr = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      pin = VECS[i].pin;
      repeat (3) @(negedge clk);
      bus_op(VECS[i].sel, VECS[i].addr, VECS[i].op, VECS[i].idx, VECS[i].wdata);
      check($sformatf("R1/R4/R7/R8 vec %0d pin_o", i), pout, VECS[i].exp_out);
      #0.1;
      check($sformatf("R6 vec %0d rdata", i), rdata, VECS[i].exp_rd);
    end

    // R2/R9: mode bit ops and output enables
    bus_op(1'b1, 1'b1, 2'b00, 3'd0, 8'h0F);
    check("R2 oe after mode 0F", poe, 8'hF0);
    bus_op(1'b1, 1'b1, 2'b01, 3'd5, 8'h00);
    check("R9 mode set bit5 oe", poe, 8'hD0);
    bus_op(1'b1, 1'b1, 2'b10, 3'd0, 8'hFF);
    addr = 1'b1; #0.1;
    check("R9 mode clear bit0 readback", rdata, 8'h2E);
    addr = 1'b0;
    check("R2 oe after clear", poe, 8'hD1);

    // R4: read strobe without we leaves latch
    bus_op(1'b1, 1'b0, 2'b00, 3'd0, 8'h77);
    check("R1 write 77", pout, 8'h77);
    sel = 1'b1; wdata = 8'h00;
    repeat (2) @(negedge clk);
    sel = 1'b0;
    check("R4 read only", pout, 8'h77);

    // R6: two-edge pin latency, all inputs
    bus_op(1'b1, 1'b1, 2'b00, 3'd0, 8'hFF);
    pin = 8'h3C;
    repeat (3) @(negedge clk);
    #0.1; check("R6 settled", rdata, 8'h3C);
    pin = 8'h81;
    @(negedge clk); #0.1;
    check("R6 one edge old", rdata, 8'h3C);
    @(negedge clk); #0.1;
    check("R6 two edges new", rdata, 8'h81);
    check("R3 no drive", poe, 8'h00);

    // R5 asynchronous reset mid-run
    rst_n = 1'b0; #1;
    check("R5 latch cleared", pout, 8'h00);
    check("R5 oe cleared", poe, 8'h00);
    finish_run();
  end
endmodule